// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block sits beside a UART's data path and turns four interrupt conditions into one interrupt line and one readable identification value. The four conditions are receive line status, receive buffer full, transmit buffer empty and modem status. Each condition latches a pending flag on its rising edge. An enable register masks each flag. A fixed-priority encoder then names the most urgent enabled source. Software reads the identification value after the line goes high, serves the named source, and reads or writes the matching register. That register access acknowledges the source.

The acknowledge paths are all side effects of register accesses, so the block takes one strobe for each access. The strobes are a line status read, a receive data read, a transmit data write, a modem status read and an identification read. The transmit-empty source can be acknowledged in two ways: by a transmit write, or by an identification read taken while transmit-empty is the reported source. The raw conditions, the shifters and the FIFOs stay outside the block.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `iir` reads 0x01, `irq` is 0 and `ien_rdata` is 0x00.
- R2: A cycle with `ien_we` high stores `ien_wdata[3:0]` as the enable bits: bit 0 receive full, bit 1 transmit empty, bit 2 line status, bit 3 modem status. `ien_rdata` returns those bits, and bits 7:4 always read 0.
- R3: `iir` bit 0 is 1 when no enabled source is pending and 0 otherwise. Bits 2:1 name the reported source: 11 for line status, 10 for receive full, 01 for transmit empty, 00 for modem status. Bits 7:3 read 0.
- R4: When several enabled sources are pending, the one reported is chosen in this order: line status first, then receive full, then transmit empty, then modem status.
- R5: The line status source is set on a rising edge of the OR of `line_stat[3:1]`, and `line_stat[0]` has no effect. It is cleared by `rd_lsr`.
- R6: The receive full source is set on a rising edge of `rx_full` and is cleared by `rd_rbr`.
- R7: The modem status source is set on a rising edge of the OR of `modem_stat[3:0]` and is cleared by `rd_msr`.
- R8: The transmit empty source is cleared by `wr_thr`. It is also cleared by `rd_iir` when `iir` reads 0x02 in that cycle. An `rd_iir` in any other cycle clears nothing.
- R9: After it is cleared, the transmit empty source stays clear while `tx_empty` is held high. It fires again only after `tx_empty` falls and then rises.
- R10: `irq` equals the inverse of `iir[0]` one clock cycle earlier.
- R11: A disabled source keeps its pending flag, and enabling it later reports it. When a set event and a clear strobe fall in the same cycle, the set wins.

Strobes and conditions are sampled on the rising clock edge. A flag set at an edge shows in `iir` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| ien_we | input | 1 | Enable register write strobe |
| ien_wdata | input | 8 | Enable register write data |
| ien_rdata | output | 8 | Enable register read data |
| line_stat | input | 4 | Raw line status bits; bits 3:1 raise the line status source |
| rx_full | input | 1 | Receive buffer full condition |
| tx_empty | input | 1 | Transmit buffer empty condition |
| modem_stat | input | 4 | Raw modem status change bits |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_rbr | input | 1 | Receive data register read strobe |
| wr_thr | input | 1 | Transmit data register write strobe |
| rd_iir | input | 1 | Identification register read strobe |
| rd_msr | input | 1 | Modem status register read strobe |
| iir | output | 8 | Identification value |
| irq | output | 1 | Registered interrupt request |

## Verification
Sources are first raised one at a time, from lowest to highest priority. Each new source must take over the reported code, which separates a correct priority order from a reversed or partial one. They are then acknowledged from highest to lowest, and each strobe must reveal the next source down, which shows that each strobe clears only its own flag. The identification-read acknowledge is tried in three states: while transmit-empty is reported, while a higher source hides it, and with nothing pending. Only the first may clear it. Further patterns cover the set-versus-clear collision, a held `tx_empty` that must not re-fire, `line_stat[0]` alone, and masking that hides a flag without losing it.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int SRC_N = 4;

  // Source index; equals the enable register bit position.
  localparam int SRC_RX = 0;
  localparam int SRC_TX = 1;
  localparam int SRC_LS = 2;
  localparam int SRC_MS = 3;

  typedef enum logic [1:0] {
    ID_MS = 2'b00,
    ID_TX = 2'b01,
    ID_RX = 2'b10,
    ID_LS = 2'b11
  } irq_id_e;

endpackage

// File: rtl/irq_ien_reg.sv
module irq_ien_reg
  import uart_irq_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [REG_W-1:0]   wdata,
  output logic [SRC_N-1:0]   en,
  output logic [REG_W-1:0]   rdata
);

  localparam int PAD_W = REG_W - SRC_N;

  logic [SRC_N-1:0] en_q;
  logic [SRC_N-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (we) en_d = wdata[SRC_N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign en    = en_q;
  assign rdata = {{PAD_W{1'b0}}, en_q};

endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);

  for (genvar i = 0; i < N; i++) begin : g_src
    logic cond_q;
    logic flag_q;
    logic flag_d;
    logic rise;

    always_comb begin
      rise   = cond[i] & ~cond_q;
      flag_d = flag_q;
      if (clr[i]) flag_d = 1'b0;
      if (rise)   flag_d = 1'b1;   // a fresh event wins over an acknowledge
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cond_q <= 1'b0;
        flag_q <= 1'b0;
      end else begin
        cond_q <= cond[i];
        flag_q <= flag_d;
      end
    end

    assign flag[i] = flag_q;
  end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic [SRC_N-1:0] pend,
  output logic             nint,
  output irq_id_e          id
);

  always_comb begin
    nint = 1'b0;
    if      (pend[SRC_LS]) id = ID_LS;
    else if (pend[SRC_RX]) id = ID_RX;
    else if (pend[SRC_TX]) id = ID_TX;
    else if (pend[SRC_MS]) id = ID_MS;
    else begin
      id   = ID_MS;
      nint = 1'b1;
    end
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int LSR_W = 4,
  parameter int MSR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ien_we,
  input  logic [REG_W-1:0] ien_wdata,
  output logic [REG_W-1:0] ien_rdata,
  input  logic [LSR_W-1:0] line_stat,
  input  logic             rx_full,
  input  logic             tx_empty,
  input  logic [MSR_W-1:0] modem_stat,
  input  logic             rd_lsr,
  input  logic             rd_rbr,
  input  logic             wr_thr,
  input  logic             rd_iir,
  input  logic             rd_msr,
  output logic [REG_W-1:0] iir,
  output logic             irq
);

  localparam int IIR_PAD = REG_W - 3;

  logic [SRC_N-1:0] en;
  logic [SRC_N-1:0] cond;
  logic [SRC_N-1:0] clr;
  logic [SRC_N-1:0] flag;
  logic [SRC_N-1:0] pend;
  logic             nint;
  irq_id_e          id;
  logic             irq_q;
  logic             irq_d;

  irq_ien_reg #(.REG_W(REG_W)) u_ien (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ien_we),
    .wdata (ien_wdata),
    .en    (en),
    .rdata (ien_rdata)
  );

  always_comb begin
    cond         = '0;
    cond[SRC_LS] = |line_stat[LSR_W-1:1];
    cond[SRC_RX] = rx_full;
    cond[SRC_TX] = tx_empty;
    cond[SRC_MS] = |modem_stat;

    clr          = '0;
    clr[SRC_LS]  = rd_lsr;
    clr[SRC_RX]  = rd_rbr;
    clr[SRC_TX]  = wr_thr | (rd_iir & ~nint & (id == ID_TX));
    clr[SRC_MS]  = rd_msr;
  end

  irq_src_bank #(.N(SRC_N)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .cond  (cond),
    .clr   (clr),
    .flag  (flag)
  );

  assign pend = flag & en;

  irq_prio_enc u_enc (
    .pend (pend),
    .nint (nint),
    .id   (id)
  );

  assign iir = {{IIR_PAD{1'b0}}, id, nint};

  always_comb irq_d = ~nint;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
  import uart_irq_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int LSR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] iir,
  input logic             irq,
  input logic [SRC_N-1:0] pend,
  input logic [LSR_W-1:0] line_stat,
  input logic             tx_empty,
  input logic             rd_lsr,
  input logic             wr_thr,
  input logic             rd_iir
);

  assert_irq_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !$past(iir[0]));

  assert_prio_ls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend[SRC_LS] |-> iir[2:0] == 3'b110);

  assert_prio_rx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[SRC_RX] && !pend[SRC_LS]) |-> iir[2:0] == 3'b100);

  assert_idle_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> iir[0]);

  assert_lsr_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !(|line_stat[LSR_W-1:1])) |=> iir[2:0] != 3'b110);

  assert_tx_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_thr || (rd_iir && iir[2:0] == 3'b010)) && !tx_empty) |=> !pend[SRC_TX]);

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.REG_W(REG_W), .LSR_W(LSR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iir       (iir),
  .irq       (irq),
  .pend      (pend),
  .line_stat (line_stat),
  .tx_empty  (tx_empty),
  .rd_lsr    (rd_lsr),
  .wr_thr    (wr_thr),
  .rd_iir    (rd_iir)
);

// File: tb/tb_uart_irq_ident.sv
`timescale 1ns/1ps
module tb_uart_irq_ident;

  logic       clk;
  logic       rst_n;
  logic       ien_we;
  logic [7:0] ien_wdata;
  logic [7:0] ien_rdata;
  logic [3:0] line_stat;
  logic       rx_full;
  logic       tx_empty;
  logic [3:0] modem_stat;
  logic       rd_lsr, rd_rbr, wr_thr, rd_iir, rd_msr;
  logic [7:0] iir;
  logic       irq;

  uart_irq_ident dut (
    .clk(clk), .rst_n(rst_n), .ien_we(ien_we), .ien_wdata(ien_wdata),
    .ien_rdata(ien_rdata), .line_stat(line_stat), .rx_full(rx_full),
    .tx_empty(tx_empty), .modem_stat(modem_stat), .rd_lsr(rd_lsr),
    .rd_rbr(rd_rbr), .wr_thr(wr_thr), .rd_iir(rd_iir), .rd_msr(rd_msr),
    .iir(iir), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    int         kind;   // 0 iir, 1 irq, 2 ien_rdata
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    total = 0;
  int    bad   = 0;

  task automatic drain();
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = iir;
        1:       act = {7'd0, irq};
        default: act = ien_rdata;
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  endtask

  initial begin
    forever begin
      @(chk_ev);
      drain();
    end
  end

  task automatic expect_val(int kind, logic [7:0] exp, string tag);
    item_t it;
    it.kind = kind;
    it.exp  = exp;
    it.tag  = tag;
    q.push_back(it);
    ->chk_ev;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ien(logic [7:0] v);
    ien_we = 1'b1; ien_wdata = v;
    tick();
    ien_we = 1'b0;
  endtask

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ien_we = 1'b0; ien_wdata = '0; line_stat = '0;
    rx_full = 1'b0; tx_empty = 1'b0; modem_stat = '0;
    rd_lsr = 1'b0; rd_rbr = 1'b0; wr_thr = 1'b0; rd_iir = 1'b0; rd_msr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_val(0, 8'h01, "R1 iir after reset");
    expect_val(1, 8'h00, "R1 irq after reset");
    expect_val(2, 8'h00, "R1 ien after reset");

    wr_ien(8'hFF);
    expect_val(2, 8'h0F, "R2 reserved bits read zero");
    expect_val(0, 8'h01, "R3 idle flag with nothing pending");

    // raise sources from lowest to highest priority
    modem_stat = 4'b0001; tick();
    expect_val(0, 8'h00, "R7 modem source reported");
    expect_val(1, 8'h00, "R10 irq not yet raised");
    tick();
    expect_val(1, 8'h01, "R10 irq one cycle later");
    tx_empty = 1'b1; tick();
    expect_val(0, 8'h02, "R4 tx over modem");
    rx_full = 1'b1; tick();
    expect_val(0, 8'h04, "R4 rx over tx");
    line_stat = 4'b0010; tick();
    expect_val(0, 8'h06, "R5 line status top priority");

    // acknowledge from highest to lowest
    line_stat = '0; rd_lsr = 1'b1; tick(); rd_lsr = 1'b0;
    expect_val(0, 8'h04, "R5 cleared by line status read");
    rx_full = 1'b0; rd_rbr = 1'b1; tick(); rd_rbr = 1'b0;
    expect_val(0, 8'h02, "R6 cleared by receive read");
    rd_iir = 1'b1; tick(); rd_iir = 1'b0;
    expect_val(0, 8'h00, "R8 ident read clears reported tx");
    modem_stat = '0; rd_msr = 1'b1; tick(); rd_msr = 1'b0;
    expect_val(0, 8'h01, "R7 cleared by modem read");
    expect_val(1, 8'h01, "R10 irq still high");
    tick();
    expect_val(1, 8'h00, "R10 irq drops one cycle later");

    rd_iir = 1'b1; tick(); rd_iir = 1'b0;
    expect_val(0, 8'h01, "R8 idle ident read no effect");
    repeat (3) tick();
    expect_val(0, 8'h01, "R9 held tx_empty does not refire");
    tx_empty = 1'b0; tick(); tx_empty = 1'b1; tick();
    expect_val(0, 8'h02, "R9 fresh tx edge refires");

    line_stat = 4'b1000; tick();
    expect_val(0, 8'h06, "R4 line status hides tx");
    rd_iir = 1'b1; tick(); rd_iir = 1'b0;
    expect_val(0, 8'h06, "R8 ident read while line status reported");
    line_stat = '0; rd_lsr = 1'b1; tick(); rd_lsr = 1'b0;
    expect_val(0, 8'h02, "R8 tx survived ident read");
    tx_empty = 1'b0; wr_thr = 1'b1; tick(); wr_thr = 1'b0;
    expect_val(0, 8'h01, "R8 cleared by transmit write");

    tx_empty = 1'b1; tick();
    expect_val(0, 8'h02, "R11 tx pending");
    wr_ien(8'h0D);
    expect_val(0, 8'h01, "R11 disabled source hidden");
    expect_val(2, 8'h0D, "R2 enable readback");
    wr_ien(8'h0F);
    expect_val(0, 8'h02, "R11 flag kept while disabled");
    line_stat = 4'b0001; tick();
    expect_val(0, 8'h02, "R5 bit0 alone ignored");
    line_stat = '0;

    tx_empty = 1'b0; wr_thr = 1'b1; tick(); wr_thr = 1'b0;
    expect_val(0, 8'h01, "R8 tx cleared before collision");
    tx_empty = 1'b1; wr_thr = 1'b1; tick(); wr_thr = 1'b0;
    expect_val(0, 8'h02, "R11 set wins over clear");
    tx_empty = 1'b0; wr_thr = 1'b1; tick(); wr_thr = 1'b0;
    expect_val(0, 8'h01, "R8 tx cleared after collision");

    modem_stat = 4'b1000; tick();
    expect_val(0, 8'h00, "R7 modem bit3 raises source");
    modem_stat = '0; rd_msr = 1'b1; tick(); rd_msr = 1'b0;
    expect_val(0, 8'h01, "R7 modem cleared");

    wr_ien(8'h01);
    rx_full = 1'b1; tick();
    expect_val(0, 8'h04, "R6 receive full reported");
    modem_stat = 4'b0010; tick();
    expect_val(0, 8'h04, "R4 rx over masked modem");
    wr_ien(8'h08);
    expect_val(0, 8'h00, "R11 modem revealed when enabled");
    expect_val(1, 8'h01, "R10 irq tracks pending");

    tick();
    drain();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule